// File: doc/BRIEF.md
# Memory Row Capacity and Boundary Generator

This block turns module geometry, already fetched from each slot's presence-detect ROM, into the values that the memory address decoder needs. Each slot holds one module. A module fills either one or two physical rows, depending on how many sides it has. For every row the block works out the capacity in 8 MB units. It also builds a running upper boundary: each row's boundary is the previous row's boundary plus that row's own capacity.

A row is always 64 data bits (8 bytes) wide. Its depth is 2 raised to the sum of its row-address bits, column-address bits and internal-bank-select bits. The row capacity in bytes is therefore 2^(sum+3). A single start pulse walks through all rows in ascending order, one row per clock, and a done pulse follows the last row. The configuration inputs must stay stable while a pass is running. A row whose geometry cannot be represented is reported as empty and carries an error flag.

Top module: `row_size_calc`

## Requirements
- R1: While reset is asserted and after it is released, row_valid, done, row_err, row_size and row_bound are all zero.
- R2: A start sampled while the block is idle begins a pass. Row 0 is presented with row_valid high one clock after that edge. The rows then follow in ascending index, one per clock, for 2*SLOTS clocks.
- R3: A present row has row_size = 2^(R+C+B-20) in 8 MB units. R and C are the row and column address counts. B is 0, 1 or 2 for an internal bank count of 1, 2 or 4, and applies to type code 2 (SDRAM).
- R4: For type code 1 (EDO) the bank-count input is ignored and B is taken as 0, whatever its value.
- R5: row_bound equals the previous row's bound plus this row's row_size. Row 0's bound equals its own size, and an empty row repeats the previous bound. The bound never wraps, even at the largest sizes in every row.
- R6: Row 2k is the first side of slot k, and row 2k+1 is its second side. With side count 2 both rows are present, and with side count 1 only row 2k is present. With side count 0 both rows are empty and have no error.
- R7: Type code 0 marks an empty slot. Both of its rows have size 0 and no error, whatever the other fields hold.
- R8: row_err is set and row_size is 0 in four cases. (a) For a present row whose sum lies outside 20..27. (b) For an SDRAM row whose bank count is not 1, 2 or 4. (c) For both rows of a slot with type code 3. (d) For both rows of a non-empty slot with side count 3.
- R9: done is high for exactly one clock, in the clock right after the last row, and row_valid is low in that clock.
- R10: A start that arrives during a pass is ignored, and the pass goes on unchanged. A start sampled in the same clock in which done rises begins a new pass at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass over all rows |
| mem_type | input | 2*SLOTS | Per-slot type: 0 empty, 1 EDO, 2 SDRAM, 3 reserved |
| row_addr_bits | input | ABITS_W*SLOTS | Per-slot row address count, excluding bank bits |
| col_addr_bits | input | ABITS_W*SLOTS | Per-slot column address count |
| dev_banks | input | 8*SLOTS | Per-slot internal bank count of the devices |
| side_cnt | input | 2*SLOTS | Per-slot number of sides (rows occupied) |
| row_valid | output | 1 | Row result is valid this clock |
| row_idx | output | $clog2(2*SLOTS) | Index of the presented row |
| row_size | output | SPAN | Row capacity in 8 MB units (one-hot or zero) |
| row_bound | output | $clog2(2*SLOTS*2^(SPAN-1)+1) | Cumulative upper boundary in 8 MB units |
| row_err | output | 1 | Row geometry is unsupported |
| done | output | 1 | One-clock pulse after the last row |

## Verification
Two events can fall in one clock: the done pulse for a finished pass, and the acceptance of a start that opens the next pass. The bench provokes this by raising start while the last row is on the outputs, so that start is sampled on the same edge that raises done. It then expects done high with row_valid low, and row 0 of the fresh pass with its bound restarted from zero on the very next clock. A start raised in the middle of a pass is also checked: the row sequence and the bounds must run on as if the start had never come.

// File: rtl/row_size_calc.sv
module row_size_calc #(
  parameter int SLOTS     = 4,
  parameter int ABITS_W   = 4,
  parameter int UNIT_LOG2 = 23,
  parameter int SPAN      = 8
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            start,
  input  logic [2*SLOTS-1:0]                              mem_type,
  input  logic [ABITS_W*SLOTS-1:0]                        row_addr_bits,
  input  logic [ABITS_W*SLOTS-1:0]                        col_addr_bits,
  input  logic [8*SLOTS-1:0]                              dev_banks,
  input  logic [2*SLOTS-1:0]                              side_cnt,
  output logic                                            row_valid,
  output logic [$clog2(2*SLOTS)-1:0]                      row_idx,
  output logic [SPAN-1:0]                                 row_size,
  output logic [$clog2(2*SLOTS*(2**(SPAN-1))+1)-1:0]      row_bound,
  output logic                                            row_err,
  output logic                                            done
);
  localparam int ROWS     = 2 * SLOTS;
  localparam int IDX_W    = $clog2(ROWS);
  localparam int BND_W    = $clog2(ROWS * (2 ** (SPAN - 1)) + 1);
  localparam int SUM_W    = ABITS_W + 2;
  localparam int MIN_BITS = UNIT_LOG2 - 3;
  localparam int MAX_BITS = MIN_BITS + SPAN - 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROWS - 1);

  typedef enum logic [1:0] {T_NONE, T_EDO, T_SDRAM, T_RSVD} mtype_t;

  logic             busy;
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-2:0] sl;
  logic             side;

  assign sl   = cur_idx[IDX_W-1:1];
  assign side = cur_idx[0];

  mtype_t           t;
  logic [ABITS_W-1:0] rb, cb;
  logic [7:0]       bk;
  logic [1:0]       sc, bb;
  logic [SUM_W-1:0] sum;
  logic             bank_ok, present, geo_ok, slot_bad, nxt_err;
  logic [SPAN-1:0]  nxt_size;

  always_comb begin
    t  = mtype_t'(mem_type[2*sl +: 2]);
    rb = row_addr_bits[ABITS_W*sl +: ABITS_W];
    cb = col_addr_bits[ABITS_W*sl +: ABITS_W];
    bk = dev_banks[8*sl +: 8];
    sc = side_cnt[2*sl +: 2];
    bb = 2'd0;
    bank_ok = 1'b1;
    if (t == T_SDRAM) begin
      case (bk)
        8'd1:    bb = 2'd0;
        8'd2:    bb = 2'd1;
        8'd4:    bb = 2'd2;
        default: bank_ok = 1'b0;
      endcase
    end
    sum      = SUM_W'(rb) + SUM_W'(cb) + SUM_W'(bb);
    slot_bad = (t == T_RSVD) || (t != T_NONE && sc == 2'd3);
    present  = (t == T_EDO || t == T_SDRAM) && sc != 2'd0 && sc != 2'd3 &&
               ({1'b0, side} < sc);
    geo_ok   = bank_ok && sum >= SUM_W'(MIN_BITS) && sum <= SUM_W'(MAX_BITS);
    nxt_err  = slot_bad || (present && !geo_ok);
    nxt_size = (present && geo_ok) ? (SPAN'(1) << (sum - SUM_W'(MIN_BITS))) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_idx   <= '0;
      row_valid <= 1'b0;
      row_idx   <= '0;
      row_size  <= '0;
      row_bound <= '0;
      row_err   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done      <= row_valid && row_idx == LAST;
      row_valid <= busy;
      if (busy) begin
        row_idx   <= cur_idx;
        row_size  <= nxt_size;
        row_err   <= nxt_err;
        row_bound <= row_bound + BND_W'(nxt_size);
        cur_idx   <= cur_idx + 1'b1;
        if (cur_idx == LAST) busy <= 1'b0;
      end else if (start) begin
        busy      <= 1'b1;
        cur_idx   <= '0;
        row_bound <= '0;
      end
    end
  end

  p_size_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> $onehot0(row_size));

  p_err_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_err) |-> row_size == '0);

  p_first_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_valid) |-> (row_idx == '0 && row_bound == BND_W'(row_size)));

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && $past(row_valid)) |-> row_idx == $past(row_idx) + 1'b1);

  p_accum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && $past(row_valid)) |-> row_bound == $past(row_bound) + BND_W'(row_size));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && $past(row_valid)) |-> row_bound >= $past(row_bound));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !row_valid);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_row_size_calc.sv
module test_row_size_calc;
  localparam int SLOTS = 4;
  localparam int ROWS  = 2 * SLOTS;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2*SLOTS-1:0] mem_type = '0;
  logic [4*SLOTS-1:0] row_addr_bits = '0, col_addr_bits = '0;
  logic [8*SLOTS-1:0] dev_banks = '0;
  logic [2*SLOTS-1:0] side_cnt = '0;
  logic        row_valid, row_err, done;
  logic [2:0]  row_idx;
  logic [7:0]  row_size;
  logic [10:0] row_bound;

  row_size_calc i_row_size_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_type(mem_type),
    .row_addr_bits(row_addr_bits), .col_addr_bits(col_addr_bits),
    .dev_banks(dev_banks), .side_cnt(side_cnt), .row_valid(row_valid),
    .row_idx(row_idx), .row_size(row_size), .row_bound(row_bound),
    .row_err(row_err), .done(done));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_slot(input int k, input int t, input int r, input int c,
                          input int b, input int s);
    mem_type[2*k +: 2]      = 2'(t);
    row_addr_bits[4*k +: 4] = 4'(r);
    col_addr_bits[4*k +: 4] = 4'(c);
    dev_banks[8*k +: 8]     = 8'(b);
    side_cnt[2*k +: 2]      = 2'(s);
  endtask

  function automatic void exp_row(input int i, output int sz, output bit er);
    int k, sd, t, sc, bb, s;
    bit ok;
    k = i / 2; sd = i % 2;
    t = int'(mem_type[2*k +: 2]); sc = int'(side_cnt[2*k +: 2]);
    sz = 0; er = 0;
    if (t == 3 || (t != 0 && sc == 3)) begin er = 1; return; end
    if (t == 0 || sd >= sc) return;
    ok = 1; bb = 0;
    if (t == 2) begin
      case (int'(dev_banks[8*k +: 8]))
        1: bb = 0;
        2: bb = 1;
        4: bb = 2;
        default: ok = 0;
      endcase
    end
    s = int'(row_addr_bits[4*k +: 4]) + int'(col_addr_bits[4*k +: 4]) + bb;
    if (!ok || s < 20 || s > 27) begin er = 1; return; end
    sz = 1 << (s - 20);
  endfunction

  task automatic begin_pass();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic walk_rows(input string tag, input bit restart, input bit poke);
    int bnd = 0;
    for (int i = 0; i < ROWS; i++) begin
      int sz;
      bit er;
      @(negedge clk);
      start = 1'b0;
      exp_row(i, sz, er);
      bnd += sz;
      chk(row_valid == 1'b1, "R2 row_valid", int'(row_valid), 1);
      chk(int'(row_idx) == i, "R2 row_idx", int'(row_idx), i);
      chk(int'(row_size) == sz, {tag, " row_size"}, int'(row_size), sz);
      chk(row_err == er, "R8 row_err", int'(row_err), int'(er));
      chk(int'(row_bound) == bnd, "R5 row_bound", int'(row_bound), bnd);
      if (poke && i == 3) start = 1'b1;
      if (restart && i == ROWS - 1) start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R9 done", int'(done), 1);
    chk(row_valid == 1'b0, "R9 valid low at done", int'(row_valid), 0);
    if (!restart) begin
      @(negedge clk);
      chk(done == 1'b0, "R9 done single", int'(done), 0);
      chk(row_valid == 1'b0, "R10 no extra pass", int'(row_valid), 0);
    end
  endtask

  function automatic int pick_banks();
    case ($urandom % 4)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return int'($urandom % 8);
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(row_valid == 1'b0 && done == 1'b0, "R1 ctrl in reset", int'({row_valid, done}), 0);
    chk(row_size == '0 && row_bound == '0 && row_err == 1'b0, "R1 data in reset",
        int'(row_bound), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(row_valid == 1'b0 && done == 1'b0 && row_bound == '0, "R1 after release",
        int'({row_valid, done}), 0);

    set_slot(0, 2, 12, 9, 4, 2);
    set_slot(1, 1, 11, 10, 7, 1);
    set_slot(2, 0, 15, 11, 3, 2);
    set_slot(3, 2, 14, 10, 4, 2);
    begin_pass();
    walk_rows("R3 R4 R6 R7", 0, 0);

    set_slot(0, 2, 12, 8, 1, 1);
    set_slot(1, 2, 15, 10, 4, 2);
    set_slot(2, 2, 11, 8, 1, 2);
    set_slot(3, 2, 15, 11, 4, 1);
    begin_pass();
    walk_rows("R8 range", 0, 0);

    set_slot(0, 3, 12, 9, 4, 1);
    set_slot(1, 2, 12, 9, 2, 3);
    set_slot(2, 2, 12, 9, 3, 1);
    set_slot(3, 0, 12, 9, 4, 3);
    begin_pass();
    walk_rows("R8 config", 1, 0);
    walk_rows("R10 restart", 0, 1);

    for (int k = 0; k < SLOTS; k++) set_slot(k, 2, 15, 10, 4, 2);
    begin_pass();
    walk_rows("R5 max", 0, 0);

    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < SLOTS; k++) begin
        int t;
        t = ($urandom % 8 < 5) ? 2 : int'($urandom % 4);
        set_slot(k, t, 10 + int'($urandom % 6), 8 + int'($urandom % 4),
                 pick_banks(), int'($urandom % 4));
      end
      begin_pass();
      walk_rows("R3 random", n % 5 == 0, n % 7 == 3);
      if (n % 5 == 0) walk_rows("R10 random restart", 0, 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule